// File: doc/BRIEF.md
# Privileged Trap Return Unit

This block carries out the two trap-return instructions of a hart with machine, supervisor and user privilege and an optional hypervisor extension. A one-cycle request pulse says which return to perform: the machine-level return or the supervisor-level return. The block also takes the present privilege and virtualization mode, the status and hypervisor-status bits involved, both saved exception PCs, and configuration flags for compressed-instruction support, the hypervisor extension, physical memory protection (with its count of configured rules) and the 1.12 privileged-spec behaviour.

One clock after the request, the block presents a registered result with a `ret_done` pulse. On success, the result is the return target PC, the rewritten status bits, the new privilege, the new virtualization mode and, when the hart re-enters a virtualized mode, a one-cycle request to swap the hypervisor register banks. If a legality check fails, the result is instead an exception cause, and every status bit and mode is passed through unchanged.

Top module: `trap_return_unit`

## Requirements
- R1: Privilege encodings are U=0, S=1, M=3. A supervisor return from U, or a machine return from any privilege other than M, gives an exception with cause 2 (illegal instruction).
- R2: When compressed support is off and bit 0 or bit 1 of the selected return PC is set, the return gives cause 0 (misaligned fetch). When compressed support is on, such a PC is returned as is.
- R3: A supervisor return gives cause 2 when the trap-supervisor-return bit is set and the hart is below M. From M the bit has no effect.
- R4: A supervisor return gives cause 22 (virtual instruction) when the hypervisor extension is present, the hart is virtualized and the virtual trap-supervisor-return bit is set. Without the extension this bit has no effect.
- R5: A successful supervisor return does the following: it sets SIE to the old SPIE, sets SPIE to 1 and SPP to 0, makes the new privilege the old SPP (0 means U, 1 means S), and sets the target to the supervisor exception PC.
- R6: A successful supervisor return clears MPRV when the 1.12 flag is set. Otherwise it keeps MPRV.
- R7: A successful supervisor return with the hypervisor extension present and virtualization off takes the new virtualization mode from the saved SPV bit and clears SPV. It raises the swap request when SPV was 1. In every other case it leaves the virtualization mode and SPV unchanged.
- R8: A successful machine return does the following: it sets MIE to the old MPIE, sets MPIE to 1, sets MPP to 0, clears MPV, makes the new privilege the old MPP, and sets the target to the machine exception PC.
- R9: A successful machine return clears MPRV only when the 1.12 flag is set and the old MPP is not M.
- R10: A machine return gives cause 1 (access fault) when memory protection is implemented with zero configured rules and the old MPP is not M.
- R11: With the hypervisor extension present, a successful machine return takes the new virtualization mode from the old MPV and raises the swap request when MPV was 1. Without the extension the mode is unchanged and no swap is requested.
- R12: The checks apply in this order: privilege, then alignment, then the trap-supervisor-return bit, then the virtual check (supervisor return) or the protection check (machine return). On an exception, privilege, virtualization and all status outputs equal the inputs, and no swap is requested.
- R13: `ret_done` and `swap_req` are single-cycle pulses, registered one clock after the request. Reset clears both pulses and `ret_exc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_req | input | 1 | One-cycle return request |
| ret_is_m | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Present privilege (U=0, S=1, M=3) |
| cur_virt | input | 1 | Present virtualization mode |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_mpv | input | 1 | Machine previous virtualization |
| st_mprv | input | 1 | Modify-privilege bit |
| st_tsr | input | 1 | Trap supervisor return |
| hs_spv | input | 1 | Hypervisor saved previous virtualization |
| hs_vtsr | input | 1 | Virtual trap supervisor return |
| sepc | input | XLEN | Supervisor exception PC |
| mepc | input | XLEN | Machine exception PC |
| cfg_c | input | 1 | Compressed instructions supported |
| cfg_h | input | 1 | Hypervisor extension present |
| cfg_pmp | input | 1 | Memory protection implemented |
| pmp_rules | input | PMP_CNT_W | Number of configured protection rules |
| cfg_v112 | input | 1 | 1.12 privileged behaviour |
| ret_done | output | 1 | Result valid pulse |
| ret_exc | output | 1 | Result is an exception |
| exc_cause | output | 5 | Exception cause code |
| tgt_pc | output | XLEN | Return target (0 on exception) |
| nx_sie | output | 1 | New SIE |
| nx_spie | output | 1 | New SPIE |
| nx_spp | output | 1 | New SPP |
| nx_mie | output | 1 | New MIE |
| nx_mpie | output | 1 | New MPIE |
| nx_mpp | output | 2 | New MPP |
| nx_mpv | output | 1 | New MPV |
| nx_mprv | output | 1 | New MPRV |
| nx_hs_spv | output | 1 | New hypervisor SPV |
| nx_priv | output | 2 | New privilege |
| nx_virt | output | 1 | New virtualization mode |
| swap_req | output | 1 | Register-bank swap pulse |

## Verification
The bench sets up requests that fail several checks at once, so a wrong check order shows up as a wrong cause code. Examples are a misaligned machine return from S, which must report illegal and not misaligned, and trap-supervisor-return together with the virtual trap bit, which must report illegal and not virtual instruction. The MPRV rules are tested with MPP equal to M and with the 1.12 flag off, to catch a design that clears the bit on every return. Exception cases carry an MPV or SPV of 1, so a design that commits state or pulses the swap request on a faulting return shows a changed mode or a spurious swap.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ACCESS   = 5'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

    typedef struct packed {
        logic       sie;
        logic       spie;
        logic       spp;
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
        logic       mpv;
        logic       mprv;
        logic       spv;
    } status_t;

    typedef struct packed {
        logic               fault;
        logic [CAUSE_W-1:0] cause;
    } verdict_t;

    function automatic logic pc_misaligned(input logic [1:0] low, input logic has_c);
        return !has_c && (low != 2'b00);
    endfunction

endpackage

// File: rtl/trapret_check.sv
module trapret_check
    import trapret_pkg::*;
(
    input  logic       is_m,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic [1:0] pc_low,
    input  logic       has_c,
    input  logic       has_h,
    input  logic       tsr,
    input  logic       vtsr,
    input  logic [1:0] mpp,
    input  logic       pmp_empty,
    output verdict_t   verdict
);
    logic priv_bad;
    logic align_bad;
    logic tsr_bad;
    logic last_bad;
    logic [CAUSE_W-1:0] last_cause;

    always_comb begin
        priv_bad  = is_m ? (priv != PRIV_M) : (priv == PRIV_U);
        align_bad = pc_misaligned(pc_low, has_c);
        tsr_bad   = !is_m && tsr && (priv != PRIV_M);
        if (is_m) begin
            last_bad   = pmp_empty && (mpp != PRIV_M);
            last_cause = CAUSE_ACCESS;
        end else begin
            last_bad   = has_h && virt && vtsr;
            last_cause = CAUSE_VIRT;
        end
    end

    always_comb begin
        verdict = '0;
        if (priv_bad) begin
            verdict.fault = 1'b1;
            verdict.cause = CAUSE_ILLEGAL;
        end else if (align_bad) begin
            verdict.fault = 1'b1;
            verdict.cause = CAUSE_MISALIGN;
        end else if (tsr_bad) begin
            verdict.fault = 1'b1;
            verdict.cause = CAUSE_ILLEGAL;
        end else if (last_bad) begin
            verdict.fault = 1'b1;
            verdict.cause = last_cause;
        end
    end
endmodule

// File: rtl/trapret_update.sv
module trapret_update
    import trapret_pkg::*;
(
    input  logic       is_m,
    input  logic       virt,
    input  status_t    st_in,
    input  logic       has_h,
    input  logic       v112,
    output status_t    st_out,
    output logic [1:0] new_priv,
    output logic       new_virt,
    output logic       swap
);
    always_comb begin
        st_out   = st_in;
        new_virt = virt;
        swap     = 1'b0;
        if (is_m) begin
            new_priv    = st_in.mpp;
            st_out.mie  = st_in.mpie;
            st_out.mpie = 1'b1;
            st_out.mpp  = PRIV_U;
            st_out.mpv  = 1'b0;
            if (v112 && (st_in.mpp != PRIV_M))
                st_out.mprv = 1'b0;
            if (has_h) begin
                new_virt = st_in.mpv;
                swap     = st_in.mpv;
            end
        end else begin
            new_priv    = st_in.spp ? PRIV_S : PRIV_U;
            st_out.sie  = st_in.spie;
            st_out.spie = 1'b1;
            st_out.spp  = 1'b0;
            if (v112)
                st_out.mprv = 1'b0;
            if (has_h && !virt) begin
                new_virt   = st_in.spv;
                st_out.spv = 1'b0;
                swap       = st_in.spv;
            end
        end
    end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
    import trapret_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int PMP_CNT_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ret_req,
    input  logic                 ret_is_m,
    input  logic [1:0]           cur_priv,
    input  logic                 cur_virt,
    input  logic                 st_sie,
    input  logic                 st_spie,
    input  logic                 st_spp,
    input  logic                 st_mie,
    input  logic                 st_mpie,
    input  logic [1:0]           st_mpp,
    input  logic                 st_mpv,
    input  logic                 st_mprv,
    input  logic                 st_tsr,
    input  logic                 hs_spv,
    input  logic                 hs_vtsr,
    input  logic [XLEN-1:0]      sepc,
    input  logic [XLEN-1:0]      mepc,
    input  logic                 cfg_c,
    input  logic                 cfg_h,
    input  logic                 cfg_pmp,
    input  logic [PMP_CNT_W-1:0] pmp_rules,
    input  logic                 cfg_v112,
    output logic                 ret_done,
    output logic                 ret_exc,
    output logic [4:0]           exc_cause,
    output logic [XLEN-1:0]      tgt_pc,
    output logic                 nx_sie,
    output logic                 nx_spie,
    output logic                 nx_spp,
    output logic                 nx_mie,
    output logic                 nx_mpie,
    output logic [1:0]           nx_mpp,
    output logic                 nx_mpv,
    output logic                 nx_mprv,
    output logic                 nx_hs_spv,
    output logic [1:0]           nx_priv,
    output logic                 nx_virt,
    output logic                 swap_req
);
    status_t         st_cur;
    status_t         st_upd;
    verdict_t        verdict;
    logic [XLEN-1:0] ret_pc;
    logic [1:0]      upd_priv;
    logic            upd_virt;
    logic            upd_swap;
    logic            pmp_empty;

    status_t            st_q;
    logic               done_q;
    logic               exc_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [XLEN-1:0]    pc_q;
    logic [1:0]         priv_q;
    logic               virt_q;
    logic               swap_q;

    always_comb begin
        st_cur      = '0;
        st_cur.sie  = st_sie;
        st_cur.spie = st_spie;
        st_cur.spp  = st_spp;
        st_cur.mie  = st_mie;
        st_cur.mpie = st_mpie;
        st_cur.mpp  = st_mpp;
        st_cur.mpv  = st_mpv;
        st_cur.mprv = st_mprv;
        st_cur.spv  = hs_spv;
        ret_pc      = ret_is_m ? mepc : sepc;
        pmp_empty   = cfg_pmp && (pmp_rules == '0);
    end

    trapret_check u_check (
        .is_m      (ret_is_m),
        .priv      (cur_priv),
        .virt      (cur_virt),
        .pc_low    (ret_pc[1:0]),
        .has_c     (cfg_c),
        .has_h     (cfg_h),
        .tsr       (st_tsr),
        .vtsr      (hs_vtsr),
        .mpp       (st_mpp),
        .pmp_empty (pmp_empty),
        .verdict   (verdict)
    );

    trapret_update u_update (
        .is_m     (ret_is_m),
        .virt     (cur_virt),
        .st_in    (st_cur),
        .has_h    (cfg_h),
        .v112     (cfg_v112),
        .st_out   (st_upd),
        .new_priv (upd_priv),
        .new_virt (upd_virt),
        .swap     (upd_swap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            exc_q   <= 1'b0;
            cause_q <= '0;
            pc_q    <= '0;
            st_q    <= '0;
            priv_q  <= PRIV_M;
            virt_q  <= 1'b0;
            swap_q  <= 1'b0;
        end else begin
            done_q <= ret_req;
            swap_q <= 1'b0;
            if (ret_req) begin
                exc_q   <= verdict.fault;
                cause_q <= verdict.cause;
                if (verdict.fault) begin
                    pc_q   <= '0;
                    st_q   <= st_cur;
                    priv_q <= cur_priv;
                    virt_q <= cur_virt;
                end else begin
                    pc_q   <= ret_pc;
                    st_q   <= st_upd;
                    priv_q <= upd_priv;
                    virt_q <= upd_virt;
                    swap_q <= upd_swap;
                end
            end
        end
    end

    assign ret_done  = done_q;
    assign ret_exc   = exc_q;
    assign exc_cause = cause_q;
    assign tgt_pc    = pc_q;
    assign nx_sie    = st_q.sie;
    assign nx_spie   = st_q.spie;
    assign nx_spp    = st_q.spp;
    assign nx_mie    = st_q.mie;
    assign nx_mpie   = st_q.mpie;
    assign nx_mpp    = st_q.mpp;
    assign nx_mpv    = st_q.mpv;
    assign nx_mprv   = st_q.mprv;
    assign nx_hs_spv = st_q.spv;
    assign nx_priv   = priv_q;
    assign nx_virt   = virt_q;
    assign swap_req  = swap_q;
endmodule

// File: rtl/trapret_sva.sv
module trapret_sva #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            ret_req,
    input logic            ret_is_m,
    input logic [1:0]      cur_priv,
    input logic            cur_virt,
    input logic [XLEN-1:0] sepc,
    input logic [XLEN-1:0] mepc,
    input logic            cfg_c,
    input logic            ret_done,
    input logic            ret_exc,
    input logic [4:0]      exc_cause,
    input logic            nx_spie,
    input logic            nx_spp,
    input logic            nx_mpie,
    input logic [1:0]      nx_mpp,
    input logic            nx_mpv,
    input logic [1:0]      nx_priv,
    input logic            nx_virt,
    input logic            swap_req
);
    logic [1:0] sel_low;
    logic       priv_ok;
    assign sel_low = ret_is_m ? mepc[1:0] : sepc[1:0];
    assign priv_ok = ret_is_m ? (cur_priv == 2'd3) : (cur_priv != 2'd0);

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        ret_req |=> ret_done); // R13
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !ret_req |=> !ret_done); // R13
    AST_SRET_FROM_U: assert property (@(posedge clk) disable iff (rst)
        ret_req && !ret_is_m && cur_priv == 2'd0 |=> ret_exc && exc_cause == 5'd2); // R1
    AST_MRET_BELOW_M: assert property (@(posedge clk) disable iff (rst)
        ret_req && ret_is_m && cur_priv != 2'd3 |=> ret_exc && exc_cause == 5'd2); // R1
    AST_MISALIGNED_PC: assert property (@(posedge clk) disable iff (rst)
        ret_req && priv_ok && !cfg_c && sel_low != 2'b00 |=> ret_exc && exc_cause == 5'd0); // R2
    AST_EXC_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        ret_done && ret_exc |-> nx_priv == $past(cur_priv) && nx_virt == $past(cur_virt) && !swap_req); // R12
    AST_SWAP_ONLY_ON_RETURN: assert property (@(posedge clk) disable iff (rst)
        swap_req |-> ret_done && !ret_exc); // R7
    AST_SRET_FIELDS: assert property (@(posedge clk) disable iff (rst)
        ret_done && !ret_exc && !$past(ret_is_m) |-> nx_spie && !nx_spp); // R5
    AST_MRET_FIELDS: assert property (@(posedge clk) disable iff (rst)
        ret_done && !ret_exc && $past(ret_is_m) |-> nx_mpie && nx_mpp == 2'd0 && !nx_mpv); // R8
endmodule

bind trap_return_unit trapret_sva #(.XLEN(XLEN)) i_trapret_sva (.*);

// File: tb/test_trap_return_unit.sv
module test_trap_return_unit;
    localparam int XLEN = 32;
    localparam int PCW  = 5;

    logic clk = 1'b0;
    logic rst;
    logic ret_req, ret_is_m, cur_virt;
    logic [1:0] cur_priv;
    logic st_sie, st_spie, st_spp, st_mie, st_mpie, st_mpv, st_mprv, st_tsr;
    logic [1:0] st_mpp;
    logic hs_spv, hs_vtsr;
    logic [XLEN-1:0] sepc, mepc;
    logic cfg_c, cfg_h, cfg_pmp, cfg_v112;
    logic [PCW-1:0] pmp_rules;
    logic ret_done, ret_exc;
    logic [4:0] exc_cause;
    logic [XLEN-1:0] tgt_pc;
    logic nx_sie, nx_spie, nx_spp, nx_mie, nx_mpie, nx_mpv, nx_mprv, nx_hs_spv;
    logic [1:0] nx_mpp, nx_priv;
    logic nx_virt, swap_req;

    int checks = 0;
    int failures = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    trap_return_unit #(.XLEN(XLEN), .PMP_CNT_W(PCW)) i_trap_return_unit (
        .clk(clk), .rst(rst), .ret_req(ret_req), .ret_is_m(ret_is_m),
        .cur_priv(cur_priv), .cur_virt(cur_virt),
        .st_sie(st_sie), .st_spie(st_spie), .st_spp(st_spp), .st_mie(st_mie),
        .st_mpie(st_mpie), .st_mpp(st_mpp), .st_mpv(st_mpv), .st_mprv(st_mprv),
        .st_tsr(st_tsr), .hs_spv(hs_spv), .hs_vtsr(hs_vtsr),
        .sepc(sepc), .mepc(mepc), .cfg_c(cfg_c), .cfg_h(cfg_h),
        .cfg_pmp(cfg_pmp), .pmp_rules(pmp_rules), .cfg_v112(cfg_v112),
        .ret_done(ret_done), .ret_exc(ret_exc), .exc_cause(exc_cause),
        .tgt_pc(tgt_pc), .nx_sie(nx_sie), .nx_spie(nx_spie), .nx_spp(nx_spp),
        .nx_mie(nx_mie), .nx_mpie(nx_mpie), .nx_mpp(nx_mpp), .nx_mpv(nx_mpv),
        .nx_mprv(nx_mprv), .nx_hs_spv(nx_hs_spv), .nx_priv(nx_priv),
        .nx_virt(nx_virt), .swap_req(swap_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        ret_req = 0; ret_is_m = 0; cur_priv = 2'd3; cur_virt = 0;
        st_sie = 0; st_spie = 0; st_spp = 0; st_mie = 0; st_mpie = 0;
        st_mpp = 2'd0; st_mpv = 0; st_mprv = 0; st_tsr = 0;
        hs_spv = 0; hs_vtsr = 0; sepc = 32'h1000; mepc = 32'h2000;
        cfg_c = 0; cfg_h = 0; cfg_pmp = 0; pmp_rules = 5'd4; cfg_v112 = 1;
    endtask

    // Issue a request at a falling edge; results are sampled at the next falling edge.
    task automatic fire(input logic is_m);
        @(negedge clk);
        ret_is_m = is_m;
        ret_req  = 1;
        @(negedge clk);
        ret_req  = 0;
    endtask

    task automatic t_reset();
        chk("R13 reset done", ret_done, 0);
        chk("R13 reset exc", ret_exc, 0);
        chk("R13 reset swap", swap_req, 0);
    endtask

    task automatic t_sret_ok();
        defaults(); cur_priv = 2'd1; st_spp = 1; st_spie = 1; st_mprv = 1;
        fire(0);
        chk("R13 sret done", ret_done, 1);
        chk("R5 sret no exc", ret_exc, 0);
        chk("R5 sret pc", tgt_pc, 32'h1000);
        chk("R5 sret sie", nx_sie, 1);
        chk("R5 sret spie", nx_spie, 1);
        chk("R5 sret spp", nx_spp, 0);
        chk("R5 sret priv", nx_priv, 1);
        chk("R6 sret mprv cleared", nx_mprv, 0);
        @(negedge clk);
        chk("R13 done is pulse", ret_done, 0);
        defaults(); cur_priv = 2'd1; cfg_v112 = 0; st_mprv = 1;
        fire(0);
        chk("R6 sret mprv kept", nx_mprv, 1);
        chk("R5 sret sie from spie 0", nx_sie, 0);
        chk("R5 sret priv U", nx_priv, 0);
    endtask

    task automatic t_sret_low();
        defaults(); cur_priv = 2'd0; st_spie = 1; st_spp = 1;
        fire(0);
        chk("R1 sret from U exc", ret_exc, 1);
        chk("R1 sret from U cause", exc_cause, 2);
        chk("R12 exc priv kept", nx_priv, 0);
        chk("R12 exc spp kept", nx_spp, 1);
        chk("R12 exc sie kept", nx_sie, 0);
    endtask

    task automatic t_align();
        defaults(); cur_priv = 2'd1; sepc = 32'h1002;
        fire(0);
        chk("R2 bit1 misaligned", exc_cause, 0);
        chk("R2 bit1 exc", ret_exc, 1);
        cfg_c = 1;
        fire(0);
        chk("R2 compressed ok", ret_exc, 0);
        chk("R2 compressed pc", tgt_pc, 32'h1002);
        defaults(); cur_priv = 2'd1; sepc = 32'h1001; st_tsr = 1;
        fire(0);
        chk("R12 align before tsr", exc_cause, 0);
    endtask

    task automatic t_tsr();
        defaults(); cur_priv = 2'd1; st_tsr = 1;
        fire(0);
        chk("R3 tsr in S exc", ret_exc, 1);
        chk("R3 tsr in S cause", exc_cause, 2);
        cur_priv = 2'd3;
        fire(0);
        chk("R3 tsr in M ok", ret_exc, 0);
    endtask

    task automatic t_vtsr();
        defaults(); cur_priv = 2'd1; cfg_h = 1; cur_virt = 1; hs_vtsr = 1;
        fire(0);
        chk("R4 vtsr cause", exc_cause, 22);
        chk("R4 vtsr exc", ret_exc, 1);
        chk("R12 vtsr keeps virt", nx_virt, 1);
        st_tsr = 1;
        fire(0);
        chk("R12 tsr before vtsr", exc_cause, 2);
        defaults(); cur_priv = 2'd1; cur_virt = 1; hs_vtsr = 1;
        fire(0);
        chk("R4 no hyp ignores vtsr", ret_exc, 0);
    endtask

    task automatic t_sret_hyp();
        defaults(); cur_priv = 2'd1; cfg_h = 1; hs_spv = 1; st_spp = 1;
        fire(0);
        chk("R7 virt from spv", nx_virt, 1);
        chk("R7 spv cleared", nx_hs_spv, 0);
        chk("R7 swap pulse", swap_req, 1);
        @(negedge clk);
        chk("R13 swap is pulse", swap_req, 0);
        hs_spv = 0;
        fire(0);
        chk("R7 spv 0 no swap", swap_req, 0);
        chk("R7 spv 0 virt", nx_virt, 0);
    endtask

    task automatic t_mret_ok();
        defaults(); st_mpp = 2'd1; st_mpie = 1; st_mpv = 1; st_mprv = 1;
        fire(1);
        chk("R8 mret no exc", ret_exc, 0);
        chk("R8 mret pc", tgt_pc, 32'h2000);
        chk("R8 mret mie", nx_mie, 1);
        chk("R8 mret mpie", nx_mpie, 1);
        chk("R8 mret mpp", nx_mpp, 0);
        chk("R8 mret mpv", nx_mpv, 0);
        chk("R8 mret priv", nx_priv, 1);
        chk("R9 mret mprv cleared", nx_mprv, 0);
        chk("R11 no hyp virt kept", nx_virt, 0);
        chk("R11 no hyp no swap", swap_req, 0);
        defaults(); st_mpp = 2'd3; st_mprv = 1;
        fire(1);
        chk("R9 mpp M keeps mprv", nx_mprv, 1);
        chk("R8 mret priv M", nx_priv, 3);
        defaults(); st_mpp = 2'd0; st_mprv = 1; cfg_v112 = 0;
        fire(1);
        chk("R9 old spec keeps mprv", nx_mprv, 1);
    endtask

    task automatic t_mret_low();
        defaults(); cur_priv = 2'd1;
        fire(1);
        chk("R1 mret from S cause", exc_cause, 2);
        chk("R1 mret from S exc", ret_exc, 1);
        mepc = 32'h2002;
        fire(1);
        chk("R12 priv before align", exc_cause, 2);
    endtask

    task automatic t_pmp();
        defaults(); cfg_pmp = 1; pmp_rules = 0; st_mpp = 2'd0;
        fire(1);
        chk("R10 pmp empty cause", exc_cause, 1);
        chk("R10 pmp empty exc", ret_exc, 1);
        st_mpp = 2'd3;
        fire(1);
        chk("R10 mpp M no fault", ret_exc, 0);
        st_mpp = 2'd0; pmp_rules = 5'd3;
        fire(1);
        chk("R10 rules present", ret_exc, 0);
        pmp_rules = 0; mepc = 32'h2001;
        fire(1);
        chk("R12 align before pmp", exc_cause, 0);
    endtask

    task automatic t_mret_hyp();
        defaults(); cfg_h = 1; st_mpv = 1; st_mpp = 2'd1;
        fire(1);
        chk("R11 virt from mpv", nx_virt, 1);
        chk("R11 swap", swap_req, 1);
        chk("R8 mpv cleared", nx_mpv, 0);
        defaults(); cfg_h = 1; st_mpv = 1; st_mpp = 2'd1; cfg_pmp = 1; pmp_rules = 0;
        fire(1);
        chk("R12 fault no swap", swap_req, 0);
        chk("R12 fault virt kept", nx_virt, 0);
        chk("R12 fault mpv kept", nx_mpv, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        defaults();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_sret_ok();
        t_sret_low();
        t_align();
        t_tsr();
        t_vtsr();
        t_sret_hyp();
        t_mret_ok();
        t_mret_low();
        t_pmp();
        t_mret_hyp();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule